// File: doc/BRIEF.md
# Word Load/Store Address and Byte-Lane Unit

This unit sits on the memory side of a load/store pipe. For each word access it computes the address to use and the new value of the base register. It covers three indexing styles. In plain-offset mode the base is left alone. In pre-indexed mode the sum of base and offset is used and written back. In post-indexed mode the old base is used and the sum is written back. The offset is a signed immediate. It is sign-extended to the address width, and the arithmetic wraps modulo 2^32.

The unit also holds a small byte-addressed memory built from four byte banks, one for each address lane. Stores split a 32-bit word into the four lanes, and loads join the four lanes back into a word. A per-request select picks little-endian order, where the lowest address holds the least significant byte, or big-endian order, where the lowest address holds the most significant byte. All results come out of registers one cycle after the request.

Top module: `lsu_agu_top`

## Requirements
- R1: With `req_mode` = 0 (plain offset), `addr_out` becomes base + offset and `wb_en` stays low.
- R2: With `req_mode` = 1 (pre-indexed), `addr_out` and `wb_value` both become base + offset, and `wb_en` is high.
- R3: With `req_mode` = 2 (post-indexed), `addr_out` is the unmodified base, `wb_value` is base + offset, and `wb_en` is high.
- R4: `req_offset` is two's complement and is sign-extended to 32 bits. The sum wraps modulo 2^32, so base 0x00000002 with offset -4 gives 0xFFFFFFFE.
- R5: `req_mode` = 3 acts exactly like mode 0: the address is base + offset and there is no writeback.
- R6: A load with `req_big` = 0 places the byte at the lowest address in bits 7:0. Bytes 0x1A, 0x2C, 0xEB, 0x0D at rising addresses read as 0x0DEB2C1A.
- R7: A load with `req_big` = 1 places the byte at the lowest address in bits 31:24. The same bytes read as 0x1A2CEB0D.
- R8: A little-endian store of 0x12345678 puts 0x78 at the lowest address and 0x12 at the highest. A big-endian store reverses this order. Reading a word back with the opposite order therefore returns 0x78563412.
- R9: `rd_valid` is high for exactly one cycle, one cycle after each load request, with `rd_data` valid in that cycle. It stays low after stores and after idle cycles.
- R10: `addr_out`, `wb_value`, `wb_en` and `rd_valid` are registered and show the request of the previous cycle. On a cycle with no request, `wb_en` and `rd_valid` are low and `addr_out` and `wb_value` keep their last values.
- R11: While `rst` is high, `addr_out`, `wb_value`, `wb_en` and `rd_valid` read zero.
- R12: Accesses are whole words. Address bits 1:0 and the bits above the memory size are ignored, so addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 same as 0 |
| req_big | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| req_base | input | 32 | Base register value |
| req_offset | input | OFS_W | Signed immediate offset |
| req_wdata | input | 32 | Store data |
| addr_out | output | 32 | Effective address of the previous request |
| wb_en | output | 1 | Base writeback enable |
| wb_value | output | 32 | New base value (base + offset) |
| rd_valid | output | 1 | Load data strobe |
| rd_data | output | 32 | Load data in the requested lane order |

## Verification
The assertions check the following on every clock edge:
- `wb_en` goes high only after a pre-indexed or post-indexed request.
- A post-indexed access reports the old base.
- A pre-indexed access reports the same value as address and writeback.
- The load strobe follows only a load request.
- Idle cycles leave both strobes low.

Byte-lane ordering, the wrap of the signed offset and the aliasing of ignored address bits can only be shown by the bench. It stores and loads words under both orders and compares them with a byte-level memory model, including the fixed example words.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE    = 2'd1,
    AM_POST   = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;
endpackage

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
  import lsu_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  offset,
  input  amode_e            mode,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] next_base,
  output logic              wb_req
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] sum;

  assign ofs_ext   = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign sum       = base + ofs_ext;
  assign next_base = sum;

  always_comb begin
    unique case (mode)
      AM_POST: acc_addr = base;
      default: acc_addr = sum;
    endcase
    wb_req = (mode == AM_PRE) || (mode == AM_POST);
  end
endmodule

// File: rtl/lsu_lane_swap.sv
module lsu_lane_swap
  import lsu_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic                 swap,
  input  logic [8*N_LANES-1:0] din,
  output logic [8*N_LANES-1:0] dout
);
  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    assign dout[8*k +: 8] = swap ? din[8*(N_LANES-1-k) +: 8] : din[8*k +: 8];
  end
endmodule

// File: rtl/lsu_byte_mem.sv
module lsu_byte_mem
  import lsu_pkg::*;
#(
  parameter int WORD_AW = 6,
  parameter int N_LANES = LANES
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [WORD_AW-1:0]   word_idx,
  input  logic [8*N_LANES-1:0] wr_lanes,
  output logic [8*N_LANES-1:0] rd_lanes
);
  localparam int DEPTH = 1 << WORD_AW;

  for (genvar g = 0; g < N_LANES; g++) begin : g_bank
    logic [7:0] bank [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (wr_en) bank[word_idx] <= wr_lanes[8*g +: 8];
      q <= bank[word_idx];
    end

    assign rd_lanes[8*g +: 8] = q;
  end
endmodule

// File: rtl/lsu_agu_top.sv
module lsu_agu_top
  import lsu_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int WORD_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_mode,
  input  logic              req_big,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] addr_out,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  amode_e            mode_c;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] next_base;
  logic              wb_req;
  logic [DATA_W-1:0] wr_lanes;
  logic [DATA_W-1:0] rd_lanes;
  logic              big_q;

  assign mode_c = amode_e'(req_mode);

  lsu_addr_calc #(.OFS_W(OFS_W)) u_calc (
    .base      (req_base),
    .offset    (req_offset),
    .mode      (mode_c),
    .acc_addr  (acc_addr),
    .next_base (next_base),
    .wb_req    (wb_req)
  );

  lsu_lane_swap #(.N_LANES(LANES)) u_wswap (
    .swap (req_big),
    .din  (req_wdata),
    .dout (wr_lanes)
  );

  lsu_byte_mem #(.WORD_AW(WORD_AW), .N_LANES(LANES)) u_mem (
    .clk      (clk),
    .wr_en    (req_valid && req_store),
    .word_idx (acc_addr[WORD_AW+LANE_W-1:LANE_W]),
    .wr_lanes (wr_lanes),
    .rd_lanes (rd_lanes)
  );

  lsu_lane_swap #(.N_LANES(LANES)) u_rswap (
    .swap (big_q),
    .din  (rd_lanes),
    .dout (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      wb_value <= '0;
      wb_en    <= 1'b0;
      rd_valid <= 1'b0;
      big_q    <= 1'b0;
    end else begin
      wb_en    <= req_valid && wb_req;
      rd_valid <= req_valid && !req_store;
      if (req_valid) begin
        addr_out <= acc_addr;
        wb_value <= next_base;
        big_q    <= req_big;
      end
    end
  end

  AST_OFS_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd0) |=> !wb_en); // R1
  AST_PRE_SAME: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd1) |=> (wb_en && addr_out == wb_value)); // R2
  AST_POST_OLD_BASE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd2) |=> (wb_en && addr_out == $past(req_base))); // R3
  AST_RSVD_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd3) |=> !wb_en); // R5
  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_store)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!wb_en && !rd_valid && $stable(addr_out))); // R10
endmodule

// File: tb/test_lsu_agu_top.sv
module test_lsu_agu_top;
  localparam int OFS_W   = 12;
  localparam int WORD_AW = 6;
  localparam int WORDS   = 1 << WORD_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             req_valid = 0, req_store = 0, req_big = 0;
  logic [1:0]       req_mode = 0;
  logic [31:0]      req_base = 0, req_wdata = 0;
  logic [OFS_W-1:0] req_offset = 0;
  logic [31:0]      addr_out, wb_value, rd_data;
  logic             wb_en, rd_valid;

  lsu_agu_top #(.OFS_W(OFS_W), .WORD_AW(WORD_AW)) i_lsu_agu_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_mode(req_mode), .req_big(req_big), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .addr_out(addr_out),
    .wb_en(wb_en), .wb_value(wb_value), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  logic [7:0] model [WORDS*4];
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] e_addr = 0, e_wbv = 0, e_rd = 0;
  logic        e_wb = 0, e_rv = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request (or idle) per cycle, compared the following cycle
  task automatic step(string tag, bit v, bit st, logic [1:0] md, bit bg,
                      logic [31:0] b, logic [OFS_W-1:0] o, logic [31:0] wd);
    logic [31:0] ext, sum, acc;
    int wi;
    req_valid = v; req_store = st; req_mode = md; req_big = bg;
    req_base = b; req_offset = o; req_wdata = wd;
    if (v) begin
      ext = 32'($signed(o));
      sum = b + ext;
      acc = (md == 2'd2) ? b : sum;
      e_addr = acc; e_wbv = sum;
      e_wb = (md == 2'd1) || (md == 2'd2);
      e_rv = !st;
      wi = int'((acc >> 2) % WORDS);
      for (int k = 0; k < 4; k++) begin
        if (st) model[wi*4+k] = bg ? wd[8*(3-k) +: 8] : wd[8*k +: 8];
        else if (bg) e_rd[8*(3-k) +: 8] = model[wi*4+k];
        else e_rd[8*k +: 8] = model[wi*4+k];
      end
    end else begin
      e_wb = 0; e_rv = 0;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check({tag, " addr"}, addr_out, e_addr);
    check({tag, " wb_value"}, wb_value, e_wbv);
    check({tag, " wb_en"}, {31'b0, wb_en}, {31'b0, e_wb});
    check("R9 rd_valid", {31'b0, rd_valid}, {31'b0, e_rv});
    if (e_rv) check(bg ? "R7 rd_data" : "R6 rd_data", rd_data, e_rd);
  endtask

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(4*200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 addr", addr_out, 0);
    check("R11 wb_value", wb_value, 0);
    check("R11 strobes", {30'b0, wb_en, rd_valid}, 0);
    rst = 0;

    for (int i = 0; i < WORDS; i++)
      step("R1", 1, 1, 2'd0, 0, i*4, 0, 32'hA5000000 ^ (i * 32'h01010101));

    // doc bytes 1A 2C EB 0D at rising addresses
    step("R1", 1, 1, 2'd0, 0, 32'h8000, 0, 32'h0DEB2C1A);
    step("R1", 1, 0, 2'd0, 0, 32'h8000, 0, 0);
    check("R6 example", rd_data, 32'h0DEB2C1A);
    step("R1", 1, 0, 2'd0, 1, 32'h8000, 0, 0);
    check("R7 example", rd_data, 32'h1A2CEB0D);

    // R8: store in one order, read in the other
    step("R2", 1, 1, 2'd1, 0, 32'h20000000, 12'd4, 32'h12345678);
    check("R2 pre addr", addr_out, 32'h20000004);
    step("R1", 1, 0, 2'd0, 1, 32'h20000004, 0, 0);
    check("R8 little store", rd_data, 32'h78563412);
    step("R3", 1, 1, 2'd2, 1, 32'h20000008, 12'd4, 32'h12345678);
    check("R3 post addr", addr_out, 32'h20000008);
    check("R3 post wb", wb_value, 32'h2000000C);
    step("R1", 1, 0, 2'd0, 0, 32'h20000008, 0, 0);
    check("R8 big store", rd_data, 32'h78563412);

    // R4 wrap and sign
    step("R4", 1, 0, 2'd0, 0, 32'h2, 12'hFFC, 0);
    check("R4 neg wrap", addr_out, 32'hFFFFFFFE);
    step("R4", 1, 0, 2'd1, 0, 32'hFFFFFFFC, 12'd8, 0);
    check("R4 pos wrap", wb_value, 32'h00000004);

    // R5 reserved mode
    step("R5", 1, 0, 2'd3, 0, 32'h100, 12'd16, 0);
    check("R5 addr", addr_out, 32'h110);
    check("R5 no wb", {31'b0, wb_en}, 0);

    // R12 ignored address bits
    step("R12", 1, 0, 2'd0, 0, 32'h8003, 0, 0);
    check("R12 low bits", rd_data, 32'h0DEB2C1A);
    step("R12", 1, 0, 2'd0, 0, 32'h8000 + WORDS*4, 0, 0);
    check("R12 high bits", rd_data, 32'h0DEB2C1A);

    // R10 idle cycles keep addresses, drop strobes
    step("R10", 0, 0, 2'd1, 0, 32'h5555, 12'd3, 0);
    step("R10", 0, 1, 2'd2, 0, 32'h7777, 12'd3, 0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step(mtag(m), ($urandom % 5) != 0, $urandom % 2, m, $urandom % 2,
           $urandom, OFS_W'($urandom), $urandom);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule